// File: doc/BRIEF.md
# Scoreboarded Out-of-Order Instruction Window

This block holds a small pool of decoded instructions and lets them leave in an order decided at run time. Instructions come in program order on the insertion port. Each one names a destination register and two source registers. A per-register busy scoreboard records which registers still have a result outstanding. An instruction is accepted only when a slot is free and no earlier instruction in the window still writes its destination. This keeps at most one pending writer per architectural register. The window therefore does without renaming and tracks readiness by register number alone.

Every slot keeps a ready flag for each source. Flags start from the scoreboard at insertion. They are set later when the writeback port broadcasts a matching register number. The same broadcast frees the register in the scoreboard.

Among the slots whose sources are both ready, the oldest is offered on the issue port. It stays offered until the execution side raises the grant. The granted slot is released at that same clock edge. A younger instruction with ready operands can therefore leave ahead of an older one that is still waiting.

Top module: `ooo_window`

## Requirements
- R1: After reset the issue port offers nothing, the window is empty and every register is free, so an insertion writing any register is accepted.
- R2: An insertion whose nonzero destination register is busy, and not broadcast in the same cycle, is refused with in_stall high in that cycle. An accepted insertion marks its nonzero destination busy from the next clock edge.
- R3: While all SLOTS slots are occupied, in_stall is high.
- R4: At insertion a source is marked ready if its register is free and waiting if it is busy. An instruction whose two sources are both ready is offered on the issue port from the cycle after its insertion.
- R5: A broadcast on the writeback port sets the ready flag of every waiting source that names the broadcast register. An instruction made fully ready this way is offered from the cycle after the broadcast.
- R6: A broadcast frees its register at the clock edge. An insertion writing that register in the same cycle as the broadcast is accepted.
- R7: An insertion whose source names the register being broadcast in the same cycle records that source as ready.
- R8: When several instructions are ready, the one inserted earliest is offered. An offer with no grant stays on the port. A grant removes the offered instruction at that edge.
- R9: A ready instruction is offered ahead of an older instruction whose sources are still waiting.
- R10: Register 0 is never busy. A destination of 0 never causes a stall, and a source of 0 is always ready.
- R11: A granted slot is free from the next cycle, so a full window accepts again. An instruction placed in a reused slot ranks as the youngest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new instruction is presented |
| in_op | input | OPW | Opcode tag of the new instruction |
| in_dst | input | RW | Destination register number |
| in_src1 | input | RW | First source register number |
| in_src2 | input | RW | Second source register number |
| in_stall | output | 1 | Insertion refused this cycle (window full or destination busy) |
| iss_valid | output | 1 | An instruction is offered for execution |
| iss_op | output | OPW | Opcode tag of the offered instruction |
| iss_dst | output | RW | Destination of the offered instruction |
| iss_src1 | output | RW | First source of the offered instruction |
| iss_src2 | output | RW | Second source of the offered instruction |
| iss_grant | input | 1 | Execution side takes the offered instruction |
| wb_valid | input | 1 | A result is broadcast |
| wb_reg | input | RW | Register number of the broadcast result |

## Verification
in_stall is combinational on the current inputs and the registered state, so the bench checks it in the same cycle as the insertion it refuses. The issue port is driven only from registered slot state. An insertion, a wakeup or a grant therefore changes what is offered exactly one edge later, and the bench checks it in the following cycle. Inputs change at the falling edge, and every output is sampled one time unit later, well before the next rising edge. Each table row states the offer that the earlier rows should have produced by that point.

// File: rtl/ooo_window.sv
module ooo_window #(
  parameter int SLOTS = 32,
  parameter int RW    = 5,
  parameter int OPW   = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] in_op,
  input  logic [RW-1:0]  in_dst,
  input  logic [RW-1:0]  in_src1,
  input  logic [RW-1:0]  in_src2,
  output logic           in_stall,
  output logic           iss_valid,
  output logic [OPW-1:0] iss_op,
  output logic [RW-1:0]  iss_dst,
  output logic [RW-1:0]  iss_src1,
  output logic [RW-1:0]  iss_src2,
  input  logic           iss_grant,
  input  logic           wb_valid,
  input  logic [RW-1:0]  wb_reg
);
  localparam int NREGS = 1 << RW;
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] vld, rdy1, rdy2;
  logic [OPW-1:0]   op_q  [SLOTS];
  logic [RW-1:0]    dst_q [SLOTS];
  logic [RW-1:0]    s1_q  [SLOTS];
  logic [RW-1:0]    s2_q  [SLOTS];
  logic [SLOTS-1:0] elder [SLOTS];   // elder[i][j]: slot j entered before slot i
  logic [NREGS-1:0] busy;

  logic [SLOTS-1:0] elig, pick;
  logic [SW-1:0]    ins_idx, iss_idx;
  logic             full, dst_blocked, accept;

  function automatic logic src_ok(input logic [RW-1:0] r);
    return (r == '0) || !busy[r] || (wb_valid && wb_reg == r);
  endfunction

  assign full        = &vld;
  assign dst_blocked = (in_dst != '0) && busy[in_dst] && !(wb_valid && wb_reg == in_dst);
  assign in_stall    = full || dst_blocked;
  assign accept      = in_valid && !in_stall;
  assign elig        = vld & rdy1 & rdy2;
  assign iss_valid   = |elig;

  for (genvar i = 0; i < SLOTS; i++) begin : g_pick
    assign pick[i] = elig[i] && !(|(elig & elder[i]));
  end

  always_comb begin
    ins_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!vld[i]) ins_idx = SW'(i);
  end

  always_comb begin
    iss_idx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (pick[i]) iss_idx = SW'(i);
  end

  assign iss_op   = op_q[iss_idx];
  assign iss_dst  = dst_q[iss_idx];
  assign iss_src1 = s1_q[iss_idx];
  assign iss_src2 = s2_q[iss_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      rdy1 <= '0;
      rdy2 <= '0;
      busy <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        elder[i] <= '0;
        op_q[i]  <= '0;
        dst_q[i] <= '0;
        s1_q[i]  <= '0;
        s2_q[i]  <= '0;
      end
    end else begin
      if (wb_valid) begin
        for (int i = 0; i < SLOTS; i++) begin
          if (vld[i] && s1_q[i] == wb_reg) rdy1[i] <= 1'b1;
          if (vld[i] && s2_q[i] == wb_reg) rdy2[i] <= 1'b1;
        end
        busy[wb_reg] <= 1'b0;
      end
      if (iss_valid && iss_grant) vld[iss_idx] <= 1'b0;
      if (accept) begin
        vld[ins_idx]   <= 1'b1;
        op_q[ins_idx]  <= in_op;
        dst_q[ins_idx] <= in_dst;
        s1_q[ins_idx]  <= in_src1;
        s2_q[ins_idx]  <= in_src2;
        rdy1[ins_idx]  <= src_ok(in_src1);
        rdy2[ins_idx]  <= src_ok(in_src2);
        elder[ins_idx] <= vld;
        for (int i = 0; i < SLOTS; i++)
          if (i != int'(ins_idx)) elder[i][ins_idx] <= 1'b0;
        if (in_dst != '0) busy[in_dst] <= 1'b1;
      end
    end
  end

  assert_zero_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy[0]);

  assert_mark_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_dst != '0 |=> busy[$past(in_dst)]);

  assert_free_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !(accept && in_dst == wb_reg) |=> !busy[$past(wb_reg)]);

  assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_grant |=> iss_valid);

  assert_free_on_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    full && iss_valid && iss_grant |=> !full);

  for (genvar i = 0; i < SLOTS; i++) begin : g_chk
    assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vld[i] && wb_valid && (s1_q[i] == wb_reg || s2_q[i] == wb_reg)
      |=> !vld[i] || (rdy1[i] && $past(s1_q[i] == wb_reg)) || (rdy2[i] && $past(s2_q[i] == wb_reg)));
  end
endmodule

// File: tb/ooo_window_bench.sv
module ooo_window_bench;
  localparam int OPW = 6;
  localparam int RW  = 5;
  localparam int NSTEP = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, iss_grant = 1'b0, wb_valid = 1'b0;
  logic [OPW-1:0] in_op = '0;
  logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0, wb_reg = '0;
  logic in_stall, iss_valid;
  logic [OPW-1:0] iss_op;
  logic [RW-1:0] iss_dst, iss_src1, iss_src2;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ooo_window u_ooo_window (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .in_stall(in_stall),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_grant(iss_grant),
    .wb_valid(wb_valid), .wb_reg(wb_reg)
  );

  // {in_valid, op, dst, src1, src2, wb_valid, wb_reg, grant, exp_stall, exp_offer, exp_op}
  localparam logic [36:0] VEC [0:NSTEP-1] = '{
    {1'b0, 6'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 6'd0},
    {1'b1, 6'd1, 5'd1, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 6'd0},
    {1'b1, 6'd2, 5'd2, 5'd1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 6'd1},
    {1'b1, 6'd3, 5'd3, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b1, 6'd1},
    {1'b1, 6'd4, 5'd1, 5'd1, 5'd0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 6'd3},
    {1'b1, 6'd4, 5'd1, 5'd1, 5'd0, 1'b1, 5'd1, 1'b0, 1'b0, 1'b0, 6'd0},
    {1'b0, 6'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b1, 6'd2},
    {1'b0, 6'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 6'd4},
    {1'b0, 6'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b1, 6'd4},
    {1'b1, 6'd5, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 6'd0},
    {1'b1, 6'd6, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 6'd5},
    {1'b0, 6'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b1, 6'd5},
    {1'b0, 6'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b1, 6'd6},
    {1'b1, 6'd7, 5'd2, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 6'd0},
    {1'b1, 6'd8, 5'd4, 5'd3, 5'd2, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 6'd0},
    {1'b1, 6'd9, 5'd5, 5'd3, 5'd3, 1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 6'd0},
    {1'b0, 6'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd2, 1'b1, 1'b0, 1'b1, 6'd9},
    {1'b0, 6'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b1, 6'd8},
    {1'b1, 6'd7, 5'd2, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 6'd0}
  };

  function automatic string tag_of(input int s);
    case (s)
      0:        return "R1";
      1, 2:     return "R4";
      3:        return "R8";
      4:        return "R2/R9";
      5:        return "R6/R7";
      6:        return "R5";
      7, 8:     return "R8";
      9, 10:    return "R10";
      11, 12:   return "R8";
      13:       return "R2";
      14:       return "R4";
      15:       return "R7";
      16, 17:   return "R5";
      default:  return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int op, input int d, input int a, input int b,
                       input logic wv, input int wr, input logic g);
    in_valid = v; in_op = OPW'(op); in_dst = RW'(d); in_src1 = RW'(a); in_src2 = RW'(b);
    wb_valid = wv; wb_reg = RW'(wr); iss_grant = g;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "stall after reset", int'(in_stall), 0);
    check("R1", "offer after reset", int'(iss_valid), 0);

    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk);
      drive(VEC[s][36], int'(VEC[s][35:30]), int'(VEC[s][29:25]), int'(VEC[s][24:20]),
            int'(VEC[s][19:15]), VEC[s][14], int'(VEC[s][13:9]), VEC[s][8]);
      #1;
      check(tag_of(s), $sformatf("step %0d stall", s), int'(in_stall), int'(VEC[s][7]));
      check(tag_of(s), $sformatf("step %0d offer", s), int'(iss_valid), int'(VEC[s][6]));
      if (VEC[s][6]) check(tag_of(s), $sformatf("step %0d op", s), int'(iss_op), int'(VEC[s][5:0]));
    end

    // R1: reset clears the scoreboard (register 1 held a pending writer)
    @(negedge clk);
    drive(1'b0, 0, 0, 0, 0, 1'b0, 0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 0, 1, 0, 0, 1'b0, 0, 1'b0);
    #1;
    check("R1", "stall on formerly busy register after reset", int'(in_stall), 0);
    check("R1", "offer after reset", int'(iss_valid), 0);

    // R3: fill every slot, nothing granted
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      drive(1'b1, k, 0, 0, 0, 1'b0, 0, 1'b0);
    end
    @(negedge clk);
    drive(1'b1, 33, 0, 0, 0, 1'b0, 0, 1'b1);
    #1;
    check("R3", "stall when full", int'(in_stall), 1);
    check("R8", "oldest offered", int'(iss_op), 0);

    // R11: freed slot accepts, and the newcomer ranks youngest
    @(negedge clk);
    drive(1'b1, 40, 0, 0, 0, 1'b0, 0, 1'b0);
    #1;
    check("R11", "stall after grant frees a slot", int'(in_stall), 0);
    for (int k = 1; k < 32; k++) begin
      @(negedge clk);
      drive(1'b0, 0, 0, 0, 0, 1'b0, 0, 1'b1);
      #1;
      check("R8", $sformatf("drain order %0d", k), int'(iss_op), k);
    end
    @(negedge clk);
    #1;
    check("R11", "reused slot offered last", int'(iss_op), 40);
    @(negedge clk);
    drive(1'b0, 0, 0, 0, 0, 1'b0, 0, 1'b0);
    #1;
    check("R8", "window empty after drain", int'(iss_valid), 0);

    finish_run();
  end
endmodule